// File: doc/BRIEF.md
# Programmable PRBS Bit Error Tester

This block is a bit error-rate tester placed on one serial port. Data moves one single-rail NRZ bit per clock. A pattern source emits either a pseudo-random sequence from a two-tap feedback polynomial x^n + x^y + 1, or a word of programmable length repeated without end. A pattern checker locks onto the same pattern in a chosen incoming stream and counts the bits it examines and the bits that differ from its prediction.

A direction control sets which side the tester faces. Facing the line, the source replaces the data going to the line and the checker watches data coming from the line. Facing the system, the source replaces the data handed to the system and the checker watches data arriving from the system. While the source is disabled, both data paths pass straight through with one register of delay. The checker runs at all times, whether the source is enabled or not.

The counters are read through a latch pulse. It copies both running counts to holding outputs and restarts the counts. A single-shot error request flips exactly one source bit, so the whole chain can be tested end to end.

Top module: `bert_core`

## Requirements
- R1: In PRBS mode (pat_rep=0) with the source enabled, every source bit b[k] equals b[k-n] XOR b[k-y], for n from poly_n (1..32) and y from poly_y (1 <= y < n).
- R2: The source never locks up at all zeros. After reset its shift state is zero, and once enabled in PRBS mode it emits a 1 within 40 bits.
- R3: In repeat mode (pat_rep=1) the source emits bits 0..rep_len-1 of rep_word in rising bit order, then starts again. rep_len ranges from 1 to 32.
- R4: With gen_en=0, line_tx_out equals sys_tx_in of the previous cycle, and sys_rx_out equals line_rx_in of the previous cycle.
- R5: With gen_en=1 and dir_sys=0, line_tx_out carries the source pattern and the checker watches line_rx_in. sys_rx_out still follows line_rx_in.
- R6: With gen_en=1 and dir_sys=1, sys_rx_out carries the source pattern and the checker watches sys_tx_in. line_tx_out still equals sys_tx_in of the previous cycle.
- R7: The checker acquires sync on a valid pattern even while gen_en=0.
- R8: The checker first loads n bits (PRBS) or rep_len bits (repeat) from its input. It then predicts each bit on its own and raises in_sync after 32 consecutive correct predictions. If any prediction fails before that, it reloads. On a clean stream, in_sync rises within 2n+40 cycles of enabling the source, or of the last error.
- R9: While in sync, 6 or more mismatches within any 64-bit window clear in_sync and restart loading. 5 mismatches inside one window keep in_sync high.
- R10: While in_sync is high, the bit count rises by one per bit and the error count by one per mismatch. A cnt_latch pulse copies both counts to bit_hold and err_hold, and the counts restart from the contribution of the latch cycle. Two latches K cycles apart in steady sync give bit_hold=K.
- R11: A one-cycle err_inject pulse inverts exactly one source bit. The pattern continues unaffected, so err_hold rises by exactly 1 and in_sync stays high.
- R12: The counters stop at their all-ones value and never wrap. With CNT_W bits, more than 2^CNT_W-1 bits in sync give bit_hold = 2^CNT_W-1.
- R13: After reset, in_sync, bit_hold, err_hold, line_tx_out and sys_rx_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one data bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Pattern source enable |
| dir_sys | input | 1 | 0: face the line, 1: face the system |
| pat_rep | input | 1 | 0: PRBS, 1: repeated word (shared by source and checker) |
| poly_n | input | CW | Polynomial order n, 1..32 |
| poly_y | input | CW | Middle tap y, 1..n-1 |
| rep_len | input | CW | Repeat length, 1..32 |
| rep_word | input | PAT_W | Repeat word, bit 0 sent first |
| err_inject | input | 1 | One-cycle request to flip one source bit |
| cnt_latch | input | 1 | One-cycle pulse: copy counts to holds, restart counts |
| sys_tx_in | input | 1 | Transmit data from the system side |
| line_tx_out | output | 1 | Transmit data toward the line |
| line_rx_in | input | 1 | Receive data from the line |
| sys_rx_out | output | 1 | Receive data toward the system side |
| in_sync | output | 1 | Checker is locked to the pattern |
| bit_hold | output | CNT_W | Latched bit count |
| err_hold | output | CNT_W | Latched error count |

## Verification
A corrupted source shift state shows up on the pattern output within n bits, because it breaks the two-tap recurrence. A stuck zero state shows up as a flat zero output within about 40 bits. A corrupted checker register or mismatch window shows up either as in_sync failing to rise inside its 2n+40-cycle bound or failing to drop after six close errors, or as err_hold differing from the exact number of injected errors at the next latch. Counter faults appear at the next cnt_latch as a bit count that differs from the cycles counted between latches, or as wrap-around instead of saturation.

// File: rtl/bert_pkg.sv
package bert_pkg;
  typedef enum logic [1:0] {
    DET_SEED   = 2'd0,
    DET_VERIFY = 2'd1,
    DET_LOCK   = 2'd2
  } det_state_e;
endpackage

// File: rtl/bert_patgen.sv
module bert_patgen #(
  parameter int PAT_W = 32,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rep,
  input  logic [CW-1:0]    n,
  input  logic [CW-1:0]    y,
  input  logic [CW-1:0]    len,
  input  logic [PAT_W-1:0] word,
  input  logic             inject,
  output logic             bit_q
);
  logic [PAT_W-1:0] lfsr;
  logic [PAT_W-1:0] mask;
  logic [CW-1:0]    idx;
  logic             fb;
  logic             pat;

  always_comb begin
    mask = (n >= CW'(PAT_W)) ? '1 : ((PAT_W'(1) << n) - PAT_W'(1));
    fb   = lfsr[n - CW'(1)] ^ lfsr[y - CW'(1)];
    pat  = rep ? word[idx] : fb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= '0;
      idx   <= '0;
      bit_q <= 1'b0;
    end else if (en) begin
      bit_q <= pat ^ inject;
      if (!rep) begin
        if ((lfsr & mask) == '0) lfsr <= '1;
        else                     lfsr <= {lfsr[PAT_W-2:0], fb};
      end
      idx <= (idx >= len - CW'(1)) ? '0 : idx + CW'(1);
    end else begin
      idx   <= '0;
      bit_q <= 1'b0;
    end
  end

  // R2: shift state is never all zero after an enabled PRBS step
  assert_no_lockup_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !rep) |=> (lfsr != '0));
endmodule

// File: rtl/bert_detect.sv
module bert_detect
  import bert_pkg::*;
#(
  parameter int PAT_W    = 32,
  parameter int CW       = 6,
  parameter int SYNC_RUN = 32,
  parameter int LOS_ERRS = 6,
  parameter int LOS_WIN  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic          rep,
  input  logic [CW-1:0] n,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] len,
  output logic          locked,
  output logic          bit_vld,
  output logic          bit_err
);
  localparam int SC_W = $clog2(SYNC_RUN + PAT_W + 1);
  localparam int WC_W = $clog2(LOS_WIN + 1);

  det_state_e       state;
  logic [PAT_W-1:0] r;
  logic [SC_W-1:0]  cnt;
  logic [LOS_WIN-1:0] hist;
  logic [WC_W-1:0]  wcnt;
  logic [WC_W-1:0]  wnext;
  logic [CW-1:0]    seed_len;
  logic             pred;
  logic             miss;

  always_comb begin
    seed_len = rep ? len : n;
    pred     = rep ? r[len - CW'(1)] : (r[n - CW'(1)] ^ r[y - CW'(1)]);
    miss     = din ^ pred;
    wnext    = wcnt + WC_W'(miss) - WC_W'(hist[LOS_WIN-1]);
  end

  assign locked = (state == DET_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DET_SEED;
      r       <= '0;
      cnt     <= '0;
      hist    <= '0;
      wcnt    <= '0;
      bit_vld <= 1'b0;
      bit_err <= 1'b0;
    end else begin
      bit_vld <= (state == DET_LOCK);
      bit_err <= (state == DET_LOCK) && miss;
      case (state)
        DET_SEED: begin
          r <= {r[PAT_W-2:0], din};
          if (cnt >= SC_W'(seed_len) - SC_W'(1)) begin
            state <= DET_VERIFY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + SC_W'(1);
          end
        end
        DET_VERIFY: begin
          r <= {r[PAT_W-2:0], pred};
          if (miss) begin
            state <= DET_SEED;
            cnt   <= '0;
          end else if (cnt == SC_W'(SYNC_RUN - 1)) begin
            state <= DET_LOCK;
            cnt   <= '0;
            hist  <= '0;
            wcnt  <= '0;
          end else begin
            cnt <= cnt + SC_W'(1);
          end
        end
        default: begin
          r    <= {r[PAT_W-2:0], pred};
          hist <= {hist[LOS_WIN-2:0], miss};
          wcnt <= wnext;
          if (wnext >= WC_W'(LOS_ERRS)) begin
            state <= DET_SEED;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

  // R9: while locked the window never holds the loss threshold
  assert_window_below_limit_R9: assert property (@(posedge clk) disable iff (rst)
    locked |-> (wcnt < WC_W'(LOS_ERRS)));
  // R8: sync is only entered from the verify phase
  assert_lock_after_verify_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(state) == DET_VERIFY));
endmodule

// File: rtl/bert_count.sv
module bert_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             err,
  input  logic             latch,
  output logic [CNT_W-1:0] bit_hold,
  output logic [CNT_W-1:0] err_hold
);
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] err_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      err_cnt  <= '0;
      bit_hold <= '0;
      err_hold <= '0;
    end else if (latch) begin
      bit_hold <= bit_cnt;
      err_hold <= err_cnt;
      bit_cnt  <= CNT_W'(vld);
      err_cnt  <= CNT_W'(vld && err);
    end else begin
      if (vld && (bit_cnt != '1))        bit_cnt <= bit_cnt + CNT_W'(1);
      if (vld && err && (err_cnt != '1)) err_cnt <= err_cnt + CNT_W'(1);
    end
  end

  // R12: counts never wrap between latches
  assert_no_wrap_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(latch) |-> (bit_cnt >= $past(bit_cnt)));
  // R10: errors are only counted on counted bits
  assert_err_within_bits_R10: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= bit_cnt);
endmodule

// File: rtl/bert_core.sv
module bert_core #(
  parameter int PAT_W    = 32,
  parameter int CNT_W    = 32,
  parameter int SYNC_RUN = 32,
  parameter int LOS_ERRS = 6,
  parameter int LOS_WIN  = 64,
  localparam int CW      = $clog2(PAT_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  input  logic             dir_sys,
  input  logic             pat_rep,
  input  logic [CW-1:0]    poly_n,
  input  logic [CW-1:0]    poly_y,
  input  logic [CW-1:0]    rep_len,
  input  logic [PAT_W-1:0] rep_word,
  input  logic             err_inject,
  input  logic             cnt_latch,
  input  logic             sys_tx_in,
  output logic             line_tx_out,
  input  logic             line_rx_in,
  output logic             sys_rx_out,
  output logic             in_sync,
  output logic [CNT_W-1:0] bit_hold,
  output logic [CNT_W-1:0] err_hold
);
  logic gen_bit;
  logic det_in;
  logic bit_vld;
  logic bit_err;

  bert_patgen #(.PAT_W(PAT_W), .CW(CW)) u_gen (
    .clk(clk), .rst(rst), .en(gen_en), .rep(pat_rep),
    .n(poly_n), .y(poly_y), .len(rep_len), .word(rep_word),
    .inject(err_inject), .bit_q(gen_bit)
  );

  assign det_in = dir_sys ? sys_tx_in : line_rx_in;

  bert_detect #(
    .PAT_W(PAT_W), .CW(CW), .SYNC_RUN(SYNC_RUN),
    .LOS_ERRS(LOS_ERRS), .LOS_WIN(LOS_WIN)
  ) u_det (
    .clk(clk), .rst(rst), .din(det_in), .rep(pat_rep),
    .n(poly_n), .y(poly_y), .len(rep_len),
    .locked(in_sync), .bit_vld(bit_vld), .bit_err(bit_err)
  );

  bert_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .vld(bit_vld), .err(bit_err),
    .latch(cnt_latch), .bit_hold(bit_hold), .err_hold(err_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_tx_out <= 1'b0;
      sys_rx_out  <= 1'b0;
    end else begin
      line_tx_out <= (gen_en && !dir_sys) ? gen_bit : sys_tx_in;
      sys_rx_out  <= (gen_en &&  dir_sys) ? gen_bit : line_rx_in;
    end
  end

  // R4: transparent paths while the source is off
  assert_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> (line_tx_out == $past(sys_tx_in)) && (sys_rx_out == $past(line_rx_in)));
  // R6: facing the system, the line transmit path stays transparent
  assert_sys_dir_tx_R6: assert property (@(posedge clk) disable iff (rst)
    (gen_en && dir_sys) |=> (line_tx_out == $past(sys_tx_in)));
  // R5: facing the line, the system receive path stays transparent
  assert_line_dir_rx_R5: assert property (@(posedge clk) disable iff (rst)
    (gen_en && !dir_sys) |=> (sys_rx_out == $past(line_rx_in)));
endmodule

// File: tb/bert_core_tb.sv
module bert_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 6;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gen_en = 0, dir_sys = 0, pat_rep = 0;
  logic [CW-1:0] poly_n = 6'd7, poly_y = 6'd6, rep_len = 6'd8;
  logic [31:0] rep_word = 32'h0;
  logic err_inject = 0, cnt_latch = 0;
  logic sys_tx_in, line_tx_out, line_rx_in, sys_rx_out, in_sync;
  logic [CNT_W-1:0] bit_hold, err_hold;
  logic rx_drv = 0, tx_drv = 0, lb_line = 0, lb_sys = 0;

  int total = 0;
  int bad = 0;
  bit cap [0:255];

  assign line_rx_in = lb_line ? line_tx_out : rx_drv;
  assign sys_tx_in  = lb_sys  ? sys_rx_out  : tx_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_core #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .gen_en(gen_en), .dir_sys(dir_sys), .pat_rep(pat_rep),
    .poly_n(poly_n), .poly_y(poly_y), .rep_len(rep_len), .rep_word(rep_word),
    .err_inject(err_inject), .cnt_latch(cnt_latch),
    .sys_tx_in(sys_tx_in), .line_tx_out(line_tx_out),
    .line_rx_in(line_rx_in), .sys_rx_out(sys_rx_out),
    .in_sync(in_sync), .bit_hold(bit_hold), .err_hold(err_hold)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; gen_en = 0; dir_sys = 0; pat_rep = 0; lb_line = 0; lb_sys = 0;
    err_inject = 0; cnt_latch = 0; rx_drv = 0; tx_drv = 0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic pulse_latch();
    cnt_latch = 1'b1; tick(); cnt_latch = 1'b0;
  endtask

  task automatic inject_one();
    err_inject = 1'b1; tick(); err_inject = 1'b0;
  endtask

  task automatic wait_sync(input int maxc, output int c);
    c = 0;
    while (!in_sync && c < maxc) begin tick(); c++; end
  endtask

  task automatic capture(input int cnt, input bit from_sys);
    for (int k = 0; k < cnt; k++) begin
      tick();
      cap[k] = from_sys ? sys_rx_out : line_tx_out;
    end
  endtask

  function automatic int prbs_bad(input int cnt, input int n, input int y, input int start);
    int b = 0;
    for (int k = start; k < cnt; k++)
      if (cap[k] != (cap[k-n] ^ cap[k-y])) b++;
    return b;
  endfunction

  function automatic int rep_bad(input int cnt, input int len, input logic [31:0] w, input int start);
    int b = 0;
    bit found = 0;
    for (int k = start + len; k < cnt; k++)
      if (cap[k] != cap[k-len]) b++;
    for (int off = 0; off < len; off++) begin
      bit all = 1;
      for (int j = 0; j < len; j++)
        if (cap[start+j] != w[(off+j) % len]) all = 0;
      if (all) found = 1;
    end
    if (!found) b++;
    return b;
  endfunction

  function automatic int ones_in(input int cnt);
    int o = 0;
    for (int k = 0; k < cnt; k++) o += int'(cap[k]);
    return o;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int c, n, y, len, b;
    logic [31:0] w, m;
    logic a, t;
    void'($urandom(32'd1234));
    do_reset();

    // R13 reset state
    check(in_sync == 0 && bit_hold == 0 && err_hold == 0 && line_tx_out == 0 && sys_rx_out == 0,
          "R13 reset state", int'(in_sync) + int'(bit_hold) + int'(err_hold), 0);

    // R4 transparent paths, random data
    b = 0;
    for (int i = 0; i < 40; i++) begin
      a = 1'($urandom_range(0, 1)); t = 1'($urandom_range(0, 1));
      rx_drv = a; tx_drv = t;
      tick();
      if (sys_rx_out != a || line_tx_out != t) b++;
    end
    check(b == 0, "R4 pass-through mismatches", b, 0);

    // R7 checker syncs with source disabled, bench-generated PRBS on the line input
    poly_n = 6'd7; poly_y = 6'd6; m = '1; c = 0;
    for (int i = 0; i < 120 && !in_sync; i++) begin
      a = m[6] ^ m[5]; m = {m[30:0], a}; rx_drv = a; tick(); c++;
    end
    check(in_sync == 1, "R7 sync with source off", int'(in_sync), 1);

    // R2 R5 R1 R8 directed: source from zero state, facing the line
    do_reset();
    poly_n = 6'd7; poly_y = 6'd6; lb_line = 1; gen_en = 1;
    capture(60, 0);
    check(ones_in(40) > 0, "R2 output leaves zero", ones_in(40), 1);
    b = prbs_bad(60, 7, 6, 12);
    check(b == 0, "R1 recurrence n=7 y=6 on line output (R5)", b, 0);
    wait_sync(60, c);
    check(in_sync == 1, "R5 R8 sync on line loopback", int'(in_sync), 1);

    // R1 R8 random polynomials
    for (int it = 0; it < 4; it++) begin
      do_reset();
      n = $urandom_range(3, 32); y = $urandom_range(1, n - 1);
      poly_n = CW'(n); poly_y = CW'(y); lb_line = 1; gen_en = 1;
      wait_sync(2*n + 40, c);
      check(in_sync == 1, $sformatf("R8 sync bound n=%0d y=%0d", n, y), c, 2*n + 40);
      capture(120, 0);
      b = prbs_bad(120, n, y, 40);
      check(b == 0, $sformatf("R1 recurrence n=%0d y=%0d", n, y), b, 0);
    end

    // R10 exact bit count between latches
    pulse_latch();
    repeat (49) tick();
    pulse_latch();
    check(bit_hold == 50, "R10 bit count over 50 cycles", int'(bit_hold), 50);
    check(err_hold == 0, "R10 no errors on clean stream", int'(err_hold), 0);

    // R11 single injected error
    pulse_latch();
    inject_one();
    repeat (10) tick();
    pulse_latch();
    check(err_hold == 1, "R11 one injected error", int'(err_hold), 1);
    check(in_sync == 1, "R11 sync kept", int'(in_sync), 1);

    // R9 five errors in window keep sync
    repeat (80) tick();
    for (int e = 0; e < 5; e++) begin inject_one(); repeat (5) tick(); end
    repeat (10) tick();
    check(in_sync == 1, "R9 five errors keep sync", int'(in_sync), 1);
    repeat (80) tick();
    for (int e = 0; e < 6; e++) begin inject_one(); repeat (5) tick(); end
    check(in_sync == 0, "R9 six errors drop sync", int'(in_sync), 0);
    wait_sync(2*n + 40, c);
    check(in_sync == 1, "R8 reacquire after loss", c, 2*n + 40);

    // R3 repeat mode, directed full length and random
    for (int it = 0; it < 3; it++) begin
      do_reset();
      len = (it == 0) ? 32 : (it == 1) ? 1 : $urandom_range(2, 31);
      w = $urandom();
      if (it == 1) w[0] = 1'b1;
      pat_rep = 1; rep_len = CW'(len); rep_word = w; lb_line = 1; gen_en = 1;
      repeat (6) tick();
      capture(3*len + 4, 0);
      b = rep_bad(3*len + 4, len, w, 0);
      check(b == 0, $sformatf("R3 repeat len=%0d", len), b, 0);
      wait_sync(2*len + 40, c);
      check(in_sync == 1, $sformatf("R8 repeat sync len=%0d", len), c, 2*len + 40);
    end

    // R6 facing the system
    do_reset();
    pat_rep = 0; poly_n = 6'd15; poly_y = 6'd14; dir_sys = 1; lb_sys = 1; gen_en = 1;
    wait_sync(80, c);
    check(in_sync == 1, "R6 sync on system loopback", int'(in_sync), 1);
    capture(80, 1);
    b = prbs_bad(80, 15, 14, 20);
    check(b == 0, "R6 R1 pattern on sys_rx_out", b, 0);
    b = 0;
    for (int i = 0; i < 20; i++) begin
      a = sys_tx_in; tick();
      if (line_tx_out != a) b++;
    end
    check(b == 0, "R6 line_tx_out follows sys_tx_in", b, 0);

    // R12 saturation of the bit counter
    pulse_latch();
    repeat (4200) tick();
    pulse_latch();
    check(bit_hold == 12'hFFF, "R12 bit count saturates", int'(bit_hold), 4095);
    check(err_hold == 0, "R12 error count stays zero", int'(err_hold), 0);

    summary();
    $finish;
  end
endmodule